// File: doc/BRIEF.md
# Retirement-Qualified Watchpoint Event Counter

This block holds a set of independent down counters (two by default, each 16 bits) that count hits on one chosen watchpoint stream. Each stream is either an instruction watchpoint or a load/store watchpoint, and each arrives as a one-cycle strobe. Hits are reported speculatively, before the instruction that caused them retires. When the pipeline later discards that instruction, a matching flush strobe for the same stream arrives. The counter then steps back up, so its value always reflects only events from instructions that really executed.

Software primes a counter through a load port and picks its stream through a per-counter select code. A counter that reaches zero raises a sticky terminal flag, which a debug controller can turn into a trap. The flag stays raised until the next load, even if a late flush moves the count away from zero. Each counter is governed by a three-state machine:

- **CNT_OFF**: no stream is selected.
- **CNT_RUN**: a stream is selected and the terminal flag is clear.
- **CNT_DONE**: the terminal flag is raised.

The transitions are:

- **LOAD**: from any state to CNT_RUN or CNT_OFF, depending on the selection in force after that cycle.
- **RESELECT**: a select write moves between CNT_OFF and CNT_RUN.
- **EXPIRE**: a counted hit that takes the count from 1 to 0 moves CNT_RUN to CNT_DONE.
- **HOLD**: every other case stays in the current state.

Top module: `wpc_event_counter`

## Requirements
- R1: After reset, every count is 0, every terminal flag is 0 and every counter has select code 0 (no stream).
- R2: Select code 0 selects nothing. Codes 1..4 select instruction watchpoint 0..3, that is bit code-1 of `iwp_hit`/`iwp_flush`. Codes 5..6 select load/store watchpoint 0..1, that is bit code-5 of `lwp_hit`/`lwp_flush`. Code 7 selects nothing.
- R3: A hit on the selected stream, with no flush and no load, lowers a non-zero count by exactly one on the next cycle. Hits on streams that are not selected leave the count unchanged.
- R4: A flush on the selected stream, with no hit and no load, raises the count by one on the next cycle. It saturates at 0xFFFF.
- R5: A hit and a flush on the selected stream in the same cycle leave the count unchanged.
- R6: A selected hit while the count is 0 leaves it at 0.
- R7: A selected hit that takes the count from 1 to 0 sets the terminal flag on the next cycle. The flag then stays set until a load, even when a flush returns the count from 0 to 1.
- R8: A load writes `ld_val` into the count and clears the terminal flag on the next cycle. It overrides any hit or flush in the same cycle.
- R9: A select write takes effect from the following cycle. Strobes in the write cycle are judged against the old code.
- R10: Counters are independent. Load, select and strobe effects on one counter never change another.
- R11: While a counter selects nothing (code 0 or 7), no hit or flush changes its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | NUM_CNT | Per-counter load strobe |
| ld_val | input | CNT_W | Value written by a load |
| sel_we | input | NUM_CNT | Per-counter select-code write strobe |
| sel_val | input | SEL_W | Select code written by `sel_we` |
| iwp_hit | input | NUM_IWP | Speculative instruction watchpoint hits |
| lwp_hit | input | NUM_LWP | Speculative load/store watchpoint hits |
| iwp_flush | input | NUM_IWP | Recovery strobes undoing instruction watchpoint hits |
| lwp_flush | input | NUM_LWP | Recovery strobes undoing load/store watchpoint hits |
| cnt_out | output | NUM_CNT*CNT_W | Current counts, counter c in bits c*CNT_W +: CNT_W |
| tc_out | output | NUM_CNT | Sticky terminal-count flags |

## Verification
A wrong stored count appears on `cnt_out` in the cycle right after the strobe that corrupted it. A wrong select code hides until a hit or flush arrives on one of the two streams it confuses. At that point the count moves when it should not, or stays still when it should move, one cycle after the strobe. A wrong state-machine state shows on `tc_out` at once, or at the next 1-to-0 step or load.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        CNT_OFF  = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_DONE = 2'd2
    } cnt_state_e;

    // A code names a live stream when it lies in 1..n_src.
    function automatic logic sel_is_live(input int code, input int n_src);
        return (code >= 1) && (code <= n_src);
    endfunction

endpackage

// File: rtl/wpc_src_mux.sv
module wpc_src_mux #(
    parameter int NUM_IWP = 4,
    parameter int NUM_LWP = 2,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_IWP-1:0] iwp_hit,
    input  logic [NUM_LWP-1:0] lwp_hit,
    input  logic [NUM_IWP-1:0] iwp_flush,
    input  logic [NUM_LWP-1:0] lwp_flush,
    output logic               ev,
    output logic               rcv
);

    always_comb begin
        ev  = 1'b0;
        rcv = 1'b0;
        for (int i = 0; i < NUM_IWP; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                ev  = iwp_hit[i];
                rcv = iwp_flush[i];
            end
        end
        for (int j = 0; j < NUM_LWP; j++) begin
            if (sel == SEL_W'(NUM_IWP + j + 1)) begin
                ev  = lwp_hit[j];
                rcv = lwp_flush[j];
            end
        end
    end

endmodule

// File: rtl/wpc_cnt_core.sv
module wpc_cnt_core
    import wpc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_val,
    input  logic             ev,
    input  logic             rcv,
    output logic [SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tc_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic [SEL_W-1:0] sel_next;
    logic             next_live;
    logic             cur_live;
    logic             expire;

    assign sel_next  = sel_we ? sel_val : sel_q;
    assign next_live = sel_is_live(int'(sel_next), N_SRC);
    assign cur_live  = sel_is_live(int'(sel_q), N_SRC);
    assign expire    = ev && !rcv && (cnt_q == CNT_ONE);

    always_comb begin
        if (ld_en)
            cnt_d = ld_val;
        else if (ev && !rcv && cnt_q != '0)
            cnt_d = cnt_q - CNT_ONE;
        else if (rcv && !ev && cnt_q != CNT_MAX)
            cnt_d = cnt_q + CNT_ONE;
        else
            cnt_d = cnt_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF, CNT_RUN: begin
                if (ld_en)
                    state_d = next_live ? CNT_RUN : CNT_OFF;
                else if (expire)
                    state_d = CNT_DONE;
                else if (sel_we)
                    state_d = next_live ? CNT_RUN : CNT_OFF;
            end
            CNT_DONE: begin
                if (ld_en)
                    state_d = next_live ? CNT_RUN : CNT_OFF;
            end
            default: state_d = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_OFF;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_next;
        end
    end

    always_comb begin
        tc_out = (state_q == CNT_DONE);
    end

    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt_q == $past(ld_val)) && !tc_out);

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ev && !rcv && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_ONE);

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && rcv && !ev && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);

    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ev && rcv) |=> $stable(cnt_q));

    assert_zero_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ev && !rcv && cnt_q == '0) |=> cnt_q == '0);

    assert_tc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && ev && !rcv && cnt_q == CNT_ONE) |=> tc_out);

    assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && !ld_en) |=> tc_out);

    assert_off_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !cur_live) |=> $stable(cnt_q));

endmodule

// File: rtl/wpc_event_counter.sv
module wpc_event_counter #(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 16,
    parameter int NUM_IWP = 4,
    parameter int NUM_LWP = 2,
    parameter int SEL_W   = $clog2(NUM_IWP + NUM_LWP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT-1:0]       ld_en,
    input  logic [CNT_W-1:0]         ld_val,
    input  logic [NUM_CNT-1:0]       sel_we,
    input  logic [SEL_W-1:0]         sel_val,
    input  logic [NUM_IWP-1:0]       iwp_hit,
    input  logic [NUM_LWP-1:0]       lwp_hit,
    input  logic [NUM_IWP-1:0]       iwp_flush,
    input  logic [NUM_LWP-1:0]       lwp_flush,
    output logic [NUM_CNT*CNT_W-1:0] cnt_out,
    output logic [NUM_CNT-1:0]       tc_out
);

    localparam int N_SRC = NUM_IWP + NUM_LWP;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        logic [SEL_W-1:0] sel_q;
        logic             ev;
        logic             rcv;

        wpc_src_mux #(
            .NUM_IWP (NUM_IWP),
            .NUM_LWP (NUM_LWP),
            .SEL_W   (SEL_W)
        ) i_mux (
            .sel       (sel_q),
            .iwp_hit   (iwp_hit),
            .lwp_hit   (lwp_hit),
            .iwp_flush (iwp_flush),
            .lwp_flush (lwp_flush),
            .ev        (ev),
            .rcv       (rcv)
        );

        wpc_cnt_core #(
            .CNT_W (CNT_W),
            .SEL_W (SEL_W),
            .N_SRC (N_SRC)
        ) i_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_en   (ld_en[c]),
            .ld_val  (ld_val),
            .sel_we  (sel_we[c]),
            .sel_val (sel_val),
            .ev      (ev),
            .rcv     (rcv),
            .sel_q   (sel_q),
            .cnt_q   (cnt_out[c*CNT_W +: CNT_W]),
            .tc_out  (tc_out[c])
        );
    end

endmodule

// File: tb/test_wpc_event_counter.sv
`timescale 1ns/1ps
module test_wpc_event_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ld_en = '0;
    logic [15:0] ld_val = '0;
    logic [1:0]  sel_we = '0;
    logic [2:0]  sel_val = '0;
    logic [3:0]  iwp_hit = '0;
    logic [1:0]  lwp_hit = '0;
    logic [3:0]  iwp_flush = '0;
    logic [1:0]  lwp_flush = '0;
    logic [31:0] cnt_out;
    logic [1:0]  tc_out;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    int m_cnt [2];
    bit m_tc  [2];
    int m_sel [2];

    always #5 clk = ~clk;

    wpc_event_counter i_wpc_event_counter (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .sel_we(sel_we), .sel_val(sel_val), .iwp_hit(iwp_hit),
        .lwp_hit(lwp_hit), .iwp_flush(iwp_flush), .lwp_flush(lwp_flush),
        .cnt_out(cnt_out), .tc_out(tc_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_tc[c] = 0; m_sel[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit e, r;
                e = 0; r = 0;
                if (m_sel[c] >= 1 && m_sel[c] <= 4) begin
                    e = iwp_hit[m_sel[c]-1]; r = iwp_flush[m_sel[c]-1];
                end else if (m_sel[c] >= 5 && m_sel[c] <= 6) begin
                    e = lwp_hit[m_sel[c]-5]; r = lwp_flush[m_sel[c]-5];
                end
                if (ld_en[c]) begin
                    m_cnt[c] = ld_val; m_tc[c] = 0;
                end else if (e && r) begin
                end else if (e) begin
                    if (m_cnt[c] > 0) begin
                        m_cnt[c] = m_cnt[c] - 1;
                        if (m_cnt[c] == 0) m_tc[c] = 1;
                    end
                end else if (r) begin
                    if (m_cnt[c] < 65535) m_cnt[c] = m_cnt[c] + 1;
                end
                if (sel_we[c]) m_sel[c] = sel_val;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            for (int c = 0; c < 2; c++) begin
                chk(cur_req, $sformatf("model count c%0d", c), int'(cnt_out[c*16 +: 16]), m_cnt[c]);
                chk(cur_req, $sformatf("model flag c%0d", c), int'(tc_out[c]), int'(m_tc[c]));
            end
        end
    end

    task automatic drv(input logic [1:0] ld, input logic [15:0] lv,
                       input logic [1:0] sw, input logic [2:0] sv,
                       input logic [3:0] ih, input logic [1:0] lh,
                       input logic [3:0] ifl, input logic [1:0] lfl);
        ld_en = ld; ld_val = lv; sel_we = sw; sel_val = sv;
        iwp_hit = ih; lwp_hit = lh; iwp_flush = ifl; lwp_flush = lfl;
        @(negedge clk);
    endtask

    function automatic int cnt(input int c);
        return int'(cnt_out[c*16 +: 16]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset count c0", cnt(0), 0);
        chk("R1", "reset count c1", cnt(1), 0);
        chk("R1", "reset flags", int'(tc_out), 0);
        cmp_on = 1'b1;

        cur_req = "R11";
        drv(2'b01, 16'd5, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 4'hF, 2'b11, 0, 0);
        chk("R11", "code 0 ignores hits", cnt(0), 5);
        drv(0, 0, 0, 0, 0, 0, 4'hF, 2'b11);
        chk("R11", "code 0 ignores flushes", cnt(0), 5);

        cur_req = "R9";
        drv(0, 0, 2'b01, 3'd1, 4'b0001, 0, 0, 0);
        chk("R9", "hit in select-write cycle uses old code", cnt(0), 5);
        cur_req = "R3";
        drv(0, 0, 0, 0, 4'b0001, 0, 0, 0);
        chk("R3", "selected hit decrements", cnt(0), 4);
        drv(0, 0, 0, 0, 4'b1110, 2'b11, 0, 0);
        chk("R3", "unselected hits ignored", cnt(0), 4);

        cur_req = "R4";
        drv(0, 0, 0, 0, 0, 0, 4'b0001, 0);
        chk("R4", "selected flush increments", cnt(0), 5);
        cur_req = "R5";
        drv(0, 0, 0, 0, 4'b0001, 0, 4'b0001, 0);
        chk("R5", "hit plus flush holds", cnt(0), 5);

        cur_req = "R8";
        drv(2'b01, 16'd1, 0, 0, 4'b0001, 0, 0, 0);
        chk("R8", "load beats hit", cnt(0), 1);
        cur_req = "R7";
        drv(0, 0, 0, 0, 4'b0001, 0, 0, 0);
        chk("R7", "count reaches zero", cnt(0), 0);
        chk("R7", "flag set on 1 to 0", int'(tc_out[0]), 1);
        cur_req = "R6";
        drv(0, 0, 0, 0, 4'b0001, 0, 0, 0);
        chk("R6", "hit at zero holds", cnt(0), 0);
        cur_req = "R7";
        drv(0, 0, 0, 0, 0, 0, 4'b0001, 0);
        chk("R7", "flush at zero gives one", cnt(0), 1);
        chk("R7", "flag stays after flush", int'(tc_out[0]), 1);
        cur_req = "R8";
        drv(2'b01, 16'd2, 0, 0, 0, 0, 4'b0001, 0);
        chk("R8", "load value", cnt(0), 2);
        chk("R8", "load clears flag", int'(tc_out[0]), 0);

        cur_req = "R2";
        drv(2'b10, 16'd2, 2'b10, 3'd6, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 4'b0001, 2'b10, 0, 0);
        chk("R2", "code 1 follows instruction stream 0", cnt(0), 1);
        chk("R2", "code 6 follows load/store stream 1", cnt(1), 1);
        cur_req = "R10";
        drv(0, 0, 0, 0, 0, 2'b01, 0, 0);
        chk("R10", "c0 untouched by c1 activity", cnt(0), 1);
        chk("R10", "c1 ignores load/store stream 0", cnt(1), 1);

        cur_req = "R4";
        drv(2'b10, 16'hFFFF, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 2'b10);
        chk("R4", "flush saturates", cnt(1), 65535);

        cur_req = "R11";
        drv(0, 0, 2'b01, 3'd7, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 4'hF, 2'b11, 0, 0);
        chk("R11", "code 7 ignores hits", cnt(0), 1);

        cur_req = "R10";
        for (int k = 0; k < 4000; k++) begin
            logic [1:0]  ld;
            logic [15:0] lv;
            logic [1:0]  sw;
            ld[0] = ($urandom_range(0, 19) == 0);
            ld[1] = ($urandom_range(0, 19) == 0);
            lv = ($urandom_range(0, 9) == 0) ? 16'(65534 + $urandom_range(0, 1))
                                             : 16'($urandom_range(0, 6));
            sw[0] = ($urandom_range(0, 29) == 0);
            sw[1] = ($urandom_range(0, 29) == 0);
            drv(ld, lv, sw, 3'($urandom_range(0, 7)),
                4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom));
        end

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule